// File: doc/BRIEF.md
# Dual-Channel Serial DAC Register Controller

This block is the digital control core of a two-channel 8-bit voltage DAC, seen from the device side. A host writes 16-bit command frames over a three-wire serial link: an active-low frame select, a serial clock and a data line. The block oversamples those three pins with a faster system clock, shifts in one bit per falling serial-clock edge while the frame select is low, and acts on a frame only at its sixteenth bit. A frame that is cut short by the frame select returning high is dropped without any effect.

Each channel holds an input code register and an output code register. A frame either loads one input register, loads one and copies both input registers to the outputs, loads both and updates both outputs, or powers both channels down. Power-down reuses the two top frame bits as a termination selector and leaves every code register as it was. The block drives the two output codes and a shared output-state encoding for the analog stage, plus a one-cycle update strobe and a one-cycle abort strobe.

The serial clock must run at no more than a quarter of the system clock. The three serial pins pass through two-flop synchronisers before any edge is detected, so results appear a few system-clock cycles after the serial edge that caused them.

Top module: `dual_dac_ctrl`

## Requirements
- R1: After reset both output codes are 0, the output state is active (encoding 00), and neither strobe is high.
- R2: Frame bits arrive most significant bit first; bit 14 picks channel A (0) or B (1), bits 13:12 are the mode, bits 11:4 are the 8-bit code, and bits 3:0 have no effect.
- R3: Mode 00 loads the addressed channel's input register and leaves both output codes and the update strobe unchanged; the loaded value becomes visible at the next output update.
- R4: Mode 01 loads the addressed channel's input register, then copies both input registers to the output codes, and pulses the update strobe.
- R5: Mode 10 loads the code into both input registers and both output codes, and pulses the update strobe.
- R6: Mode 11 sets the output state of both channels from frame bits 15:14 (00 or 11 gives high impedance, encoding 01; 01 gives 2.5 kOhm to ground, encoding 10; 10 gives 100 kOhm to ground, encoding 11), keeps both output codes, and pulses the update strobe.
- R7: Any accepted frame of mode 00, 01 or 10 returns the output state to active (00), including mode 00, which changes no output code.
- R8: If the frame select rises after 1 to 15 bits, the abort strobe pulses for one cycle and no code, state or update strobe changes.
- R9: Serial-clock edges after the sixteenth bit are ignored until the frame select goes high again.
- R10: A frame with bit 15 set and a mode other than 11 is ignored entirely: no register, state or strobe changes.
- R11: Both channels always report the same output state.
- R12: The update strobe is high for exactly one system-clock cycle per accepted frame of mode 01, 10 or 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 4x the serial clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sync_ni | input | 1 | Frame select, active low |
| sclk_i | input | 1 | Serial clock; data taken on its falling edge |
| sdi_i | input | 1 | Serial data, most significant bit first |
| code_a_o | output | 8 | Output code of channel A |
| code_b_o | output | 8 | Output code of channel B |
| state_a_o | output | 2 | Channel A output state: 00 active, 01 high-Z, 10 2.5 kOhm, 11 100 kOhm |
| state_b_o | output | 2 | Channel B output state, same encoding |
| upd_o | output | 1 | One-cycle strobe on each accepted updating frame |
| abort_o | output | 1 | One-cycle strobe when a frame is cut short |

## Verification
The hardest condition to reach from the ports is a frame that is cut or overrun exactly at its boundary: the frame select rising after the fifteenth bit must abort, while extra clock pulses after the sixteenth must be ignored. The bench has one serial-write task that takes a bit count and an extra-pulse count, so it can stop a frame at 10 or 15 bits or run 4 pulses past the sixteenth with data held high. The input register written by a mode-00 frame is not visible at the ports, so the bench exposes it with a following mode-01 write to the other channel, which copies both input registers to the outputs.

// File: rtl/dac_ctrl_pkg.sv
package dac_ctrl_pkg;

  typedef enum logic [1:0] {
    MODE_WR_HOLD = 2'b00,
    MODE_WR_UPD  = 2'b01,
    MODE_WR_ALL  = 2'b10,
    MODE_PDOWN   = 2'b11
  } dac_mode_e;

  typedef enum logic [1:0] {
    OUT_ACTIVE = 2'b00,
    OUT_HIZ    = 2'b01,
    OUT_R2K5   = 2'b10,
    OUT_R100K  = 2'b11
  } out_state_e;

  function automatic out_state_e term_decode(input logic [1:0] sel);
    case (sel)
      2'b01:   return OUT_R2K5;
      2'b10:   return OUT_R100K;
      default: return OUT_HIZ;
    endcase
  endfunction

endpackage

// File: rtl/dac_sync.sv
module dac_sync #(
  parameter int          W       = 3,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] meta_q, stab_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= RST_VAL;
      stab_q <= RST_VAL;
    end else begin
      meta_q <= d_i;
      stab_q <= meta_q;
    end
  end

  assign q_o = stab_q;

endmodule

// File: rtl/dac_frame_rx.sv
module dac_frame_rx #(
  parameter int FRAME_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sync_ni,
  input  logic               sclk_i,
  input  logic               sdi_i,
  output logic               frame_vld_o,
  output logic [FRAME_W-1:0] frame_o,
  output logic               abort_o
);

  localparam int CNT_W = $clog2(FRAME_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_W - 1);

  logic               sync_prev_q, sclk_prev_q;
  logic               armed_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [FRAME_W-2:0] shreg_q;
  logic               sync_fall, sync_rise, sclk_fall;

  assign sync_fall = sync_prev_q & ~sync_ni;
  assign sync_rise = ~sync_prev_q & sync_ni;
  assign sclk_fall = sclk_prev_q & ~sclk_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_prev_q <= 1'b1;
      sclk_prev_q <= 1'b0;
      armed_q     <= 1'b0;
      cnt_q       <= '0;
      shreg_q     <= '0;
      frame_vld_o <= 1'b0;
      frame_o     <= '0;
      abort_o     <= 1'b0;
    end else begin
      sync_prev_q <= sync_ni;
      sclk_prev_q <= sclk_i;
      frame_vld_o <= 1'b0;
      abort_o     <= 1'b0;
      if (sync_fall) begin
        armed_q <= 1'b1;
        cnt_q   <= '0;
      end else if (sync_rise) begin
        // partial frame: drop it
        abort_o <= armed_q && (cnt_q != '0);
        armed_q <= 1'b0;
      end else if (armed_q && sclk_fall) begin
        shreg_q <= {shreg_q[FRAME_W-3:0], sdi_i};
        cnt_q   <= cnt_q + 1'b1;
        if (cnt_q == LAST_BIT) begin
          armed_q     <= 1'b0;
          frame_vld_o <= 1'b1;
          frame_o     <= {shreg_q, sdi_i};
        end
      end
    end
  end

endmodule

// File: rtl/dac_reg_bank.sv
module dac_reg_bank
  import dac_ctrl_pkg::*;
#(
  parameter int FRAME_W = 16,
  parameter int CODE_W  = 8,
  parameter int NCH     = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  frame_vld_i,
  input  logic [FRAME_W-1:0]    frame_i,
  output logic [NCH*CODE_W-1:0] codes_o,
  output out_state_e            state_o,
  output logic                  upd_o
);

  localparam int ADDR_W  = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int ADDR_HI = FRAME_W - 2;
  localparam int MODE_HI = FRAME_W - 3;
  localparam int CODE_HI = FRAME_W - 5;

  dac_mode_e         mode;
  logic [ADDR_W-1:0] addr;
  logic [CODE_W-1:0] code;
  logic              accept, do_upd;
  logic [CODE_HI-CODE_W:0] unused_low;

  assign mode       = dac_mode_e'(frame_i[MODE_HI -: 2]);
  assign addr       = frame_i[ADDR_HI -: ADDR_W];
  assign code       = frame_i[CODE_HI -: CODE_W];
  assign unused_low = frame_i[CODE_HI-CODE_W:0];
  // top bit must be clear except when it doubles as a termination select
  assign accept = frame_vld_i && ((mode == MODE_PDOWN) || !frame_i[FRAME_W-1]);
  assign do_upd = accept && ((mode == MODE_WR_UPD) || (mode == MODE_WR_ALL));

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    logic [CODE_W-1:0] in_q, out_q, in_d;
    logic              wr_sel;

    assign wr_sel = accept && ((mode == MODE_WR_ALL) ||
                    (((mode == MODE_WR_HOLD) || (mode == MODE_WR_UPD)) &&
                     (addr == ADDR_W'(ch))));
    assign in_d   = wr_sel ? code : in_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        in_q  <= '0;
        out_q <= '0;
      end else begin
        in_q <= in_d;
        if (do_upd) out_q <= in_d;
      end
    end

    assign codes_o[ch*CODE_W +: CODE_W] = out_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_o <= OUT_ACTIVE;
      upd_o   <= 1'b0;
    end else begin
      upd_o <= accept && (mode != MODE_WR_HOLD);
      if (accept) begin
        state_o <= (mode == MODE_PDOWN) ? term_decode(frame_i[FRAME_W-1 -: 2])
                                        : OUT_ACTIVE;
      end
    end
  end

endmodule

// File: rtl/dual_dac_ctrl.sv
module dual_dac_ctrl
  import dac_ctrl_pkg::*;
#(
  parameter int FRAME_W = 16,
  parameter int CODE_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sync_ni,
  input  logic              sclk_i,
  input  logic              sdi_i,
  output logic [CODE_W-1:0] code_a_o,
  output logic [CODE_W-1:0] code_b_o,
  output logic [1:0]        state_a_o,
  output logic [1:0]        state_b_o,
  output logic              upd_o,
  output logic              abort_o
);

  localparam int NCH = 2;

  logic [2:0]           pins_s;
  logic                 frame_vld;
  logic [FRAME_W-1:0]   frame;
  logic [NCH*CODE_W-1:0] codes;
  out_state_e           state;

  dac_sync #(
    .W       (3),
    .RST_VAL (3'b100)
  ) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({sync_ni, sclk_i, sdi_i}),
    .q_o    (pins_s)
  );

  dac_frame_rx #(
    .FRAME_W (FRAME_W)
  ) i_rx (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sync_ni     (pins_s[2]),
    .sclk_i      (pins_s[1]),
    .sdi_i       (pins_s[0]),
    .frame_vld_o (frame_vld),
    .frame_o     (frame),
    .abort_o     (abort_o)
  );

  dac_reg_bank #(
    .FRAME_W (FRAME_W),
    .CODE_W  (CODE_W),
    .NCH     (NCH)
  ) i_bank (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .frame_vld_i (frame_vld),
    .frame_i     (frame),
    .codes_o     (codes),
    .state_o     (state),
    .upd_o       (upd_o)
  );

  assign code_a_o  = codes[0 +: CODE_W];
  assign code_b_o  = codes[CODE_W +: CODE_W];
  assign state_a_o = state;
  assign state_b_o = state;

endmodule

// File: rtl/dual_dac_ctrl_chk.sv
module dual_dac_ctrl_chk #(
  parameter int CODE_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [CODE_W-1:0] code_a_o,
  input logic [CODE_W-1:0] code_b_o,
  input logic [1:0]        state_a_o,
  input logic [1:0]        state_b_o,
  input logic              upd_o,
  input logic              abort_o
);

  // R11
  state_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_a_o == state_b_o);

  // R12
  upd_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_o |=> !upd_o);

  // R8
  abort_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |-> ($stable(code_a_o) && $stable(code_b_o) && $stable(state_a_o)));

  // R8
  strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(upd_o && abort_o));

  // R3
  code_needs_upd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(code_a_o) || !$stable(code_b_o)) |-> upd_o);

  // R6
  pdown_needs_upd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(state_a_o) && (state_a_o != 2'b00)) |-> upd_o);

  // R7
  wake_quiet_codes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(state_a_o) && (state_a_o == 2'b00) && !upd_o) |->
      ($stable(code_a_o) && $stable(code_b_o)));

endmodule

bind dual_dac_ctrl dual_dac_ctrl_chk #(.CODE_W(CODE_W)) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .code_a_o  (code_a_o),
  .code_b_o  (code_b_o),
  .state_a_o (state_a_o),
  .state_b_o (state_b_o),
  .upd_o     (upd_o),
  .abort_o   (abort_o)
);

// File: tb/test_dual_dac_ctrl.sv
module test_dual_dac_ctrl;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       sync_ni = 1'b1;
  logic       sclk_i = 1'b0;
  logic       sdi_i = 1'b0;
  logic [7:0] code_a_o, code_b_o;
  logic [1:0] state_a_o, state_b_o;
  logic       upd_o, abort_o;

  int n_chk = 0;
  int n_fail = 0;
  int upd_pulses = 0;
  int upd_cycles = 0;
  int abort_pulses = 0;
  logic upd_prev = 1'b0;
  logic abort_prev = 1'b0;
  bit   done = 1'b0;

  always #2 clk = ~clk;

  dual_dac_ctrl i_dual_dac_ctrl (
    .clk_i     (clk),
    .rst_ni    (rst_ni),
    .sync_ni   (sync_ni),
    .sclk_i    (sclk_i),
    .sdi_i     (sdi_i),
    .code_a_o  (code_a_o),
    .code_b_o  (code_b_o),
    .state_a_o (state_a_o),
    .state_b_o (state_b_o),
    .upd_o     (upd_o),
    .abort_o   (abort_o)
  );

  always @(negedge clk) begin
    if (upd_o) upd_cycles++;
    if (upd_o && !upd_prev) upd_pulses++;
    if (abort_o && !abort_prev) abort_pulses++;
    upd_prev   <= upd_o;
    abort_prev <= abort_o;
  end

  // {frame[15:0], code_a[7:0], code_b[7:0], state[1:0], upd}
  localparam int NV = 12;
  localparam logic [34:0] VEC [NV] = '{
    {16'h1AB0, 8'hAB, 8'h00, 2'b00, 1'b1},
    {16'h4CD0, 8'hAB, 8'h00, 2'b00, 1'b0},
    {16'h0120, 8'hAB, 8'h00, 2'b00, 1'b0},
    {16'h5EF0, 8'h12, 8'hEF, 2'b00, 1'b1},
    {16'h277F, 8'h77, 8'h77, 2'b00, 1'b1},
    {16'h3000, 8'h77, 8'h77, 2'b01, 1'b1},
    {16'h7000, 8'h77, 8'h77, 2'b10, 1'b1},
    {16'hB000, 8'h77, 8'h77, 2'b11, 1'b1},
    {16'hF000, 8'h77, 8'h77, 2'b01, 1'b1},
    {16'h0055, 8'h77, 8'h77, 2'b00, 1'b0},
    {16'h9990, 8'h77, 8'h77, 2'b00, 1'b0},
    {16'h1C30, 8'hC3, 8'h77, 2'b00, 1'b1}
  };

  function automatic string vec_tag(input int i);
    case (i)
      0, 3:       return "R4";
      1, 2:       return "R3";
      4:          return "R5";
      5, 6, 7, 8: return "R6";
      9:          return "R7";
      10:         return "R10";
      default:    return "R2";
    endcase
  endfunction

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  task automatic sclk_pulse(input logic bitv);
    sdi_i = bitv;
    repeat (4) @(negedge clk);
    sclk_i = 1'b1;
    repeat (8) @(negedge clk);
    sclk_i = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic send(input logic [15:0] w, input int nbits, input int extra);
    @(negedge clk);
    sync_ni = 1'b0;
    repeat (8) @(negedge clk);
    for (int i = 0; i < nbits; i++) sclk_pulse(w[15-i]);
    for (int i = 0; i < extra; i++) sclk_pulse(1'b1);
    repeat (8) @(negedge clk);
    sync_ni = 1'b1;
    sdi_i   = 1'b0;
    repeat (40) @(negedge clk);
  endtask

  task automatic expect_out(input string tag, input logic [7:0] a,
                            input logic [7:0] b, input logic [1:0] st);
    chk(tag, "code_a", 32'(code_a_o), 32'(a));
    chk(tag, "code_b", 32'(code_b_o), 32'(b));
    chk(tag, "state_a", 32'(state_a_o), 32'(st));
    chk(tag, "state_b", 32'(state_b_o), 32'(st));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R1 watchdog act=hung exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int up0, ab0;
    repeat (5) @(negedge clk);
    // R1 reset state
    expect_out("R1", 8'h00, 8'h00, 2'b00);
    chk("R1", "upd", 32'(upd_o), 0);
    chk("R1", "abort", 32'(abort_o), 0);
    rst_ni = 1'b1;
    repeat (10) @(negedge clk);
    expect_out("R1", 8'h00, 8'h00, 2'b00);

    for (int i = 0; i < NV; i++) begin
      up0 = upd_pulses;
      ab0 = abort_pulses;
      send(VEC[i][34:19], 16, 0);
      expect_out(vec_tag(i), VEC[i][18:11], VEC[i][10:3], VEC[i][2:1]);
      chk(vec_tag(i), "upd_pulses", 32'(upd_pulses - up0), 32'(VEC[i][0]));
      chk(vec_tag(i), "abort_pulses", 32'(abort_pulses - ab0), 0);
    end

    // R8 abort after 10 bits, then after 15 bits
    up0 = upd_pulses;
    ab0 = abort_pulses;
    send(16'h2FF0, 10, 0);
    expect_out("R8", 8'hC3, 8'h77, 2'b00);
    chk("R8", "abort_10", 32'(abort_pulses - ab0), 1);
    send(16'h3000, 15, 0);
    expect_out("R8", 8'hC3, 8'h77, 2'b00);
    chk("R8", "abort_15", 32'(abort_pulses - ab0), 2);
    chk("R8", "upd_none", 32'(upd_pulses - up0), 0);

    // R9 extra pulses after 16th bit ignored
    up0 = upd_pulses;
    ab0 = abort_pulses;
    send(16'h2110, 16, 4);
    expect_out("R9", 8'h11, 8'h11, 2'b00);
    chk("R9", "upd_once", 32'(upd_pulses - up0), 1);
    chk("R9", "no_abort", 32'(abort_pulses - ab0), 0);

    // R6 codes kept through power-down, R7 wake with mode 01 on B
    send(16'h7000, 16, 0);
    expect_out("R6", 8'h11, 8'h11, 2'b10);
    send(16'h5440, 16, 0);
    expect_out("R7", 8'h11, 8'h44, 2'b00);

    // R12 strobe width
    chk("R12", "upd_width", 32'(upd_cycles), 32'(upd_pulses));

    // R1 reset while powered down
    send(16'hB000, 16, 0);
    expect_out("R6", 8'h11, 8'h44, 2'b11);
    @(negedge clk);
    rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    expect_out("R1", 8'h00, 8'h00, 2'b00);
    rst_ni = 1'b1;
    repeat (5) @(negedge clk);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule